// File: doc/BRIEF.md
# Signed Sequential Shift-Add Multiplier

This block multiplies two W-bit two's-complement numbers and returns their exact 2W-bit two's-complement product. It trades speed for area. It uses one 2W-bit adder and spends W clock cycles on each operation, looking at one multiplier bit per cycle, starting with the least significant bit. When that bit is set, the multiplicand is added to a running sum. The multiplicand is sign-extended to 2W bits and shifted left by the current bit position.

In two's complement the most significant multiplier bit has negative weight. For that bit the shifted multiplicand is therefore subtracted from the sum, not added. The same adder performs the subtraction by taking the bitwise inverse of the term and setting its carry input.

A caller pulses `start` for one cycle while `busy` is low and presents both operands at the same time. The block captures the operands on that edge. It raises `done` for one cycle when `product` is valid, and `product` keeps that value until the next operation completes.

Top module: `smul_seq`

## Requirements
- R1: `product` equals the mathematically exact signed product of the captured multiplicand and multiplier, written as a 2W-bit two's-complement value (top bit is the sign). This holds for every operand pair, including the most negative value times itself.
- R2: `start` is accepted only on a rising edge where `busy` is low. A `start` pulse while `busy` is high has no effect on the running result and does not cause an extra `done` pulse.
- R3: `done` rises on the W-th rising edge after the edge that accepted `start`. `busy` is high from the accepting edge up to that edge, and `busy` and `done` are never high together.
- R4: `done` is high for exactly one clock cycle per accepted operation.
- R5: `product` changes only on the edge where `done` rises, and otherwise holds its last value.
- R6: When the multiplier's sign bit is 1, the shifted multiplicand for that bit is subtracted. This gives correct results such as -3 × -5 = 15 and 13 × -11 = -143. No other bit position ever subtracts.
- R7: A zero multiplicand or a zero multiplier gives a product of 0.
- R8: While `rst_n` is low, `busy`, `done` and `product` are all 0.
- R9: Operands are sampled only on the accepting edge. Changing `mcand_in` or `mplier_in` while `busy` is high has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation request, sampled only while idle |
| mcand_in | input | W | Multiplicand, two's complement |
| mplier_in | input | W | Multiplier, two's complement |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: `product` is valid |
| product | output | 2W | Signed product, held until the next completion |

## Verification
Each fault shows up at the ports within W+1 cycles of an accepted `start`:

- **Wrong subtraction for the sign bit:** a bad carry-in, or the inverse applied at the wrong step, gives wrong products. These appear whenever the multiplier is negative.
- **Corrupted shift register:** the product has a missing or misplaced partial product.
- **Faulty step counter:** `done` appears on the wrong edge, or never appears.
- **Operand path not frozen after capture:** the result follows late operand changes.

Exhaustive operand pairs at W=4 and constrained random pairs at W=8 expose these faults on the first operation that uses the affected bit. Late operand changes and `start` pulses are injected while `busy` is high.

// File: rtl/smul_pkg.sv
package smul_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smul_state_e;

endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load_evt,
  output logic step_evt,
  output logic last_evt
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  smul_state_e state_q;
  logic [CW-1:0] step_q;

  assign busy     = (state_q == ST_RUN);
  assign load_evt = start && (state_q == ST_IDLE);
  assign step_evt = (state_q == ST_RUN);
  assign last_evt = step_evt && (step_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else if (load_evt) begin
      state_q <= ST_RUN;
      step_q  <= '0;
    end else if (last_evt) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else if (step_evt) begin
      step_q  <= step_q + 1'b1;
    end
  end

endmodule

// File: rtl/smul_addsub.sv
module smul_addsub #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] term,
  input  logic          negate,
  output logic [AW-1:0] sum
);

  // subtraction = add inverse plus one, one adder for both
  function automatic logic [AW-1:0] accumulate(
    input logic [AW-1:0] base,
    input logic [AW-1:0] t,
    input logic          neg
  );
    logic [AW-1:0] operand;
    operand = neg ? ~t : t;
    return base + operand + {{(AW-1){1'b0}}, neg};
  endfunction

  assign sum = accumulate(acc, term, negate);

endmodule

// File: rtl/smul_dp.sv
module smul_dp #(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_evt,
  input  logic            step_evt,
  input  logic            last_evt,
  input  logic [W-1:0]    mcand_in,
  input  logic [W-1:0]    mplier_in,
  input  logic [2*W-1:0]  sum,
  output logic [2*W-1:0]  acc,
  output logic [2*W-1:0]  term,
  output logic            add_en,
  output logic            neg_en,
  output logic [2*W-1:0]  product,
  output logic            done
);

  localparam int PW = 2 * W;

  function automatic logic [PW-1:0] sext(input logic [W-1:0] v);
    return {{W{v[W-1]}}, v};
  endfunction

  logic [PW-1:0] mcand_q;
  logic [W-1:0]  mplier_q;
  logic [PW-1:0] acc_q;
  logic [PW-1:0] acc_next;

  assign add_en   = step_evt && mplier_q[0];
  assign neg_en   = add_en && last_evt;
  assign acc      = acc_q;
  assign term     = mcand_q;
  assign acc_next = add_en ? sum : acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load_evt) begin
      mcand_q  <= sext(mcand_in);
      mplier_q <= mplier_in;
      acc_q    <= '0;
    end else if (step_evt) begin
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
      acc_q    <= acc_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= last_evt;
      if (last_evt) product <= acc_next;
    end
  end

endmodule

// File: rtl/smul_seq.sv
module smul_seq #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     mcand_in,
  input  logic [W-1:0]     mplier_in,
  output logic             busy,
  output logic             done,
  output logic [2*W-1:0]   product
);

  localparam int PW = 2 * W;

  logic          load_evt;
  logic          step_evt;
  logic          last_evt;
  logic          add_en;
  logic          neg_en;
  logic [PW-1:0] acc;
  logic [PW-1:0] term;
  logic [PW-1:0] sum;

  smul_ctrl #(.W(W)) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .last_evt (last_evt)
  );

  smul_dp #(.W(W)) i_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .step_evt  (step_evt),
    .last_evt  (last_evt),
    .mcand_in  (mcand_in),
    .mplier_in (mplier_in),
    .sum       (sum),
    .acc       (acc),
    .term      (term),
    .add_en    (add_en),
    .neg_en    (neg_en),
    .product   (product),
    .done      (done)
  );

  smul_addsub #(.AW(PW)) i_addsub (
    .acc    (acc),
    .term   (term),
    .negate (neg_en),
    .sum    (sum)
  );

endmodule

// File: rtl/smul_seq_chk.sv
module smul_seq_chk #(
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [W-1:0]     mcand_in,
  input logic [W-1:0]     mplier_in,
  input logic             busy,
  input logic             done,
  input logic [2*W-1:0]   product,
  input logic             load_evt,
  input logic             step_evt,
  input logic             last_evt,
  input logic             add_en,
  input logic             neg_en
);

  localparam int PW  = 2 * W;
  localparam int LCW = $clog2(W + 1) + 1;

  logic [PW-1:0]  exp_q;
  logic [LCW-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= '0;
      lat_q <= '0;
    end else if (load_evt) begin
      exp_q <= $signed({{W{mcand_in[W-1]}}, mcand_in}) *
               $signed({{W{mplier_in[W-1]}}, mplier_in});
      lat_q <= '0;
    end else if (busy) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  p_exact_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (product == exp_q));

  p_start_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !last_evt) |=> (busy && !done));

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LCW'(W)));

  p_busy_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_product_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));

  p_sub_only_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    neg_en |-> (last_evt && add_en && step_evt));

  p_load_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (start && !busy));

  p_reset_state_r8: assert property (@(posedge clk)
    !rst_n |-> (!busy && !done && product == '0));

endmodule

bind smul_seq smul_seq_chk #(.W(W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .mcand_in  (mcand_in),
  .mplier_in (mplier_in),
  .busy      (busy),
  .done      (done),
  .product   (product),
  .load_evt  (load_evt),
  .step_evt  (step_evt),
  .last_evt  (last_evt),
  .add_en    (add_en),
  .neg_en    (neg_en)
);

// File: tb/test_smul_seq.sv
module test_smul_seq;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic        st8 = 1'b0;
  logic [7:0]  a8 = '0, b8 = '0;
  logic        busy8, done8;
  logic [15:0] p8;

  logic        st4 = 1'b0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic        busy4, done4;
  logic [7:0]  p4;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smul_seq #(.W(8)) i_smul_seq (
    .clk(clk), .rst_n(rst_n), .start(st8), .mcand_in(a8), .mplier_in(b8),
    .busy(busy8), .done(done8), .product(p8)
  );

  smul_seq #(.W(4)) i_smul_seq_w4 (
    .clk(clk), .rst_n(rst_n), .start(st4), .mcand_in(a4), .mplier_in(b4),
    .busy(busy4), .done(done4), .product(p4)
  );

  function automatic longint sx(input longint v, input int w);
    longint m;
    m = v & ((longint'(1) << w) - 1);
    if (m >= (longint'(1) << (w - 1))) m = m - (longint'(1) << w);
    return m;
  endfunction

  function automatic longint ref_mul(input int w, input longint a, input longint b);
    return sx(a, w) * sx(b, w);
  endfunction

  function automatic longint get_prod(input bit sm);
    if (sm) return sx(longint'(p4), 8);
    return sx(longint'(p8), 16);
  endfunction

  function automatic bit get_done(input bit sm);
    return sm ? done4 : done8;
  endfunction

  function automatic bit get_busy(input bit sm);
    return sm ? busy4 : busy8;
  endfunction

  task automatic drive(input bit sm, input longint a, input longint b, input bit s);
    if (sm) begin st4 = s; a4 = a[3:0]; b4 = b[3:0]; end
    else    begin st8 = s; a8 = a[7:0]; b8 = b[7:0]; end
  endtask

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one complete operation; disturb injects start and operand changes while busy
  task automatic do_op(input bit sm, input longint a, input longint b,
                       input string req, input bit disturb);
    int w;
    int k;
    longint exp;
    longint held;
    w = sm ? 4 : 8;
    exp = ref_mul(w, a, b);
    @(negedge clk);
    drive(sm, a, b, 1'b1);
    @(negedge clk);
    k = 1;
    check(get_busy(sm) == 1'b1, "R3 busy after start", longint'(get_busy(sm)), 1);
    if (disturb) drive(sm, ~a, b + 3, 1'b1);
    else drive(sm, a, b, 1'b0);
    while (!get_done(sm) && k < w + 4) begin
      @(negedge clk);
      k++;
      if (disturb) drive(sm, a ^ longint'(k), ~b, 1'b0);
    end
    check(k == w + 1, "R3 latency", longint'(k), longint'(w + 1));
    check(get_busy(sm) == 1'b0, "R3 busy low at done", longint'(get_busy(sm)), 0);
    check(get_prod(sm) == exp, req, get_prod(sm), exp);
    held = get_prod(sm);
    drive(sm, 0, 0, 1'b0);
    @(negedge clk);
    check(get_done(sm) == 1'b0, "R4 done single cycle", longint'(get_done(sm)), 0);
    check(get_prod(sm) == held, "R5 product held", get_prod(sm), held);
    if (disturb) begin
      for (int i = 0; i < w + 2; i++) begin
        @(negedge clk);
        check(get_done(sm) == 1'b0, "R2 no extra done", longint'(get_done(sm)), 0);
      end
      check(get_prod(sm) == held, "R2 product unchanged", get_prod(sm), held);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R8 reset state
    check(busy8 == 1'b0 && done8 == 1'b0, "R8 reset flags w8", longint'({busy8, done8}), 0);
    check(p8 == '0, "R8 reset product w8", longint'(p8), 0);
    check(busy4 == 1'b0 && done4 == 1'b0 && p4 == '0, "R8 reset w4", longint'(p4), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corner cases
    do_op(1'b0, -3, -5, "R6 -3*-5", 1'b0);
    do_op(1'b0, 13, -11, "R6 13*-11", 1'b0);
    do_op(1'b0, -128, -128, "R1 min*min", 1'b0);
    do_op(1'b0, -128, 127, "R1 min*max", 1'b0);
    do_op(1'b0, 127, -128, "R6 max*min", 1'b0);
    do_op(1'b0, -1, -1, "R6 -1*-1", 1'b0);
    do_op(1'b0, 0, -77, "R7 zero multiplicand", 1'b0);
    do_op(1'b0, -99, 0, "R7 zero multiplier", 1'b0);
    do_op(1'b0, 45, -3, "R9 operands frozen", 1'b1);
    do_op(1'b1, -3, -5, "R6 -3*-5 w4", 1'b0);
    do_op(1'b1, -8, -8, "R1 min*min w4", 1'b0);

    // exhaustive W=4
    for (int x = -8; x < 8; x++)
      for (int y = -8; y < 8; y++)
        do_op(1'b1, longint'(x), longint'(y), "R1 exhaustive w4", 1'b0);

    // constrained random W=8, with disturbance every fourth operation (R2, R9)
    for (int n = 0; n < 300; n++) begin
      longint ra;
      longint rb;
      ra = sx(longint'($urandom), 8);
      rb = sx(longint'($urandom), 8);
      if (n % 10 == 1) rb = -128;
      if (n % 10 == 2) ra = -128;
      do_op(1'b0, ra, rb, (rb < 0) ? "R6 random negative multiplier" : "R1 random",
            (n % 4) == 3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule